// File: doc/BRIEF.md
# Message SPI Master

This block is an SPI master that runs a complete multi-byte message per command instead of moving one word per register access. Software loads outgoing bytes into a transmit FIFO, programs a message control word with a byte count and a message kind, then writes a command carrying the target device number. The sequencer shifts the whole message with one select line held low. Bytes received during the message go into a receive FIFO, which software drains through a data port.

The block supports three message kinds. A full-duplex message exchanges one byte each way per slot. A half-duplex write only sends bytes. A half-duplex read first sends a short prepend of command bytes and then clocks in the requested bytes with MOSI held low. Bit timing is paced by a strobe from an external clock generator, and every strobe produces one SCLK edge. Five sticky interrupt flags, gated by a mask, drive one interrupt line. Transfers longer than a FIFO are split in software: wait for command done, drain the receive FIFO until it reports empty, refill the transmit FIFO and issue another start.

Top module: `spi_msg_master`

## Requirements
- R1: After reset all selects are high, SCLK and the interrupt are low, the status register reads 0x02 and both tail registers read 0.
- R2: The register map uses 4-bit addresses:
  - 0x0: command low byte (a write executes it).
  - 0x1: command high byte.
  - 0x2: message byte count.
  - 0x3: message control high byte, with the message kind in bits 7:6 (0 = full duplex, 1 = half-duplex write, 2 = half-duplex read).
  - 0x4: transmit data.
  - 0x5: receive data.
  - 0x6: status.
  - 0x7: interrupt flags.
  - 0x8: interrupt mask.
  - 0x9: transmit tail.
  - 0xA: receive tail.
- R3: The command is 16 bits wide. Bits 3:0 hold a one-hot code: 1 = no-op, 2 = soft reset, 4 = hard reset, 8 = start. Bits 5:4 hold the device number and bits 10:8 the prepend count. When several code bits are set, hard reset wins over soft reset, and soft reset wins over start.
- R4: A full-duplex message shifts byte-count bytes out of the transmit FIFO, MSB first, and stores each byte sampled on MISO in the receive FIFO.
- R5: A half-duplex write message shifts its bytes out and stores nothing.
- R6: A half-duplex read message first shifts out prepend-count bytes from the transmit FIFO and stores nothing for them. It then shifts byte-count more bytes with MOSI low and stores each one.
- R7: The select of the commanded device is the only low select, from the start until the last byte ends. SCLK idles low and changes only on a strobe. MISO is sampled on the rising edge and MOSI changes on the falling edge.
- R8: The transmit tail reads the number of loaded bytes. A write to a full transmit FIFO (capacity 63) is dropped and sets flag bit 3.
- R9: When a byte must be sent and the transmit FIFO is empty, 0x00 is sent and flag bit 2 is set.
- R10: A received byte that finds the receive FIFO full is dropped and sets flag bit 1. A read of the empty receive FIFO returns 0x00 and sets flag bit 4.
- R11: The end of a message sets flag bit 0. Writing 1 to a flag bit clears it. The interrupt is the OR of flags AND mask. The status register has bit 1 = receive empty, bit 2 = command busy, bit 3 = shifter busy.
- R12: A soft reset empties both FIFOs and stops the sequencer but keeps the mask and the message control. A hard reset also clears the mask, the message control, the command high byte and the flags.
- R13: A start with a zero total length sets flag bit 0 at once without lowering any select. A no-op command leaves all selects high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 4 | Register address |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (pops the receive data port) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |
| shift_stb_i | input | 1 | Bit-timing strobe, one SCLK edge per pulse |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | 4 | Active-low device selects |

## Verification
The embedded assertions check on every cycle the rules that hold at any instant:
- At most one select is low.
- SCLK is low in idle and holds its level between strobes.
- A full FIFO keeps its count when pushed.
- A write-1 clears a flag.
- A soft reset leaves both FIFOs empty and the sequencer idle.

The byte content of each message kind, the prepend split, the substitution on underflow, the drop on overflow and the command priority can only be shown by the bench's scenarios. In those scenarios a behavioural slave exchanges bytes, and the captured bytes are compared with queues of expected values.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;
  typedef enum logic [1:0] {
    MSG_FULL_DUPLEX = 2'd0,
    MSG_HALF_WRITE  = 2'd1,
    MSG_HALF_READ   = 2'd2,
    MSG_RESERVED    = 2'd3
  } msg_kind_e;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_LOAD,
    SEQ_SHIFT,
    SEQ_END
  } seq_state_e;

  localparam logic [3:0] A_CMD_LO  = 4'h0;
  localparam logic [3:0] A_CMD_HI  = 4'h1;
  localparam logic [3:0] A_MSG_LO  = 4'h2;
  localparam logic [3:0] A_MSG_HI  = 4'h3;
  localparam logic [3:0] A_TXD     = 4'h4;
  localparam logic [3:0] A_RXD     = 4'h5;
  localparam logic [3:0] A_STAT    = 4'h6;
  localparam logic [3:0] A_INT_ST  = 4'h7;
  localparam logic [3:0] A_INT_MSK = 4'h8;
  localparam logic [3:0] A_TX_TAIL = 4'h9;
  localparam logic [3:0] A_RX_TAIL = 4'hA;

  localparam int unsigned IRQ_W      = 5;
  localparam int unsigned IRQ_DONE   = 0;
  localparam int unsigned IRQ_RX_OVF = 1;
  localparam int unsigned IRQ_TX_UNF = 2;
  localparam int unsigned IRQ_TX_OVF = 3;
  localparam int unsigned IRQ_RX_UNF = 4;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PRE_W  = 3;
endpackage

// File: rtl/spi_msg_fifo.sv
module spi_msg_fifo #(
  parameter int unsigned DEPTH = 63,
  parameter int unsigned DW    = 8,
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic             push_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             pop_i,
  output logic [DW-1:0]    rdata_o,
  output logic [CNT_W-1:0] count_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [DW-1:0]    mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic             do_push, do_pop;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (cnt == CNT_W'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i & ~full_o & ~flush_i;
  assign do_pop  = pop_i & ~empty_o & ~flush_i;
  assign rdata_o = mem[rd_ptr];
  assign count_o = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else if (flush_i) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      cnt <= cnt + CNT_W'(do_push) - CNT_W'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end

  // R8
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (count_o == CNT_W'(DEPTH)));
endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
  import spi_msg_pkg::*;
#(
  parameter int unsigned CNT_W = 8,
  parameter int unsigned NDEV  = 4,
  localparam int unsigned DEV_W = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int unsigned TOT_W = CNT_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              abort_i,
  input  logic              start_i,
  input  msg_kind_e         kind_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic [PRE_W-1:0]  pre_cnt_i,
  input  logic [DEV_W-1:0]  dev_i,
  input  logic              strobe_i,
  input  logic              miso_i,
  input  logic [BYTE_W-1:0] tx_byte_i,
  input  logic              tx_empty_i,
  output logic              tx_pop_o,
  output logic              tx_unf_o,
  output logic              rx_push_o,
  output logic [BYTE_W-1:0] rx_byte_o,
  output logic              done_o,
  output logic              busy_o,
  output logic              shifting_o,
  output logic              sclk_o,
  output logic              mosi_o,
  output logic [NDEV-1:0]   cs_n_o
);
  seq_state_e        state;
  msg_kind_e         kind_q;
  logic [TOT_W-1:0]  rem, total;
  logic [PRE_W-1:0]  pre_left;
  logic [DEV_W-1:0]  dev_q;
  logic [BYTE_W-1:0] tx_sh, rx_sh;
  logic [2:0]        bit_q;
  logic              sclk_q, store_q, out_phase;

  assign total = TOT_W'(byte_cnt_i) +
                 ((kind_i == MSG_HALF_READ) ? TOT_W'(pre_cnt_i) : TOT_W'(0));
  assign out_phase  = (kind_q != MSG_HALF_READ) || (pre_left != '0);
  assign tx_pop_o   = (state == SEQ_LOAD) && out_phase && !tx_empty_i;
  assign tx_unf_o   = (state == SEQ_LOAD) && out_phase && tx_empty_i;
  assign rx_push_o  = (state == SEQ_END) && store_q;
  assign rx_byte_o  = rx_sh;
  assign done_o     = ((state == SEQ_END) && (rem == TOT_W'(1))) ||
                      ((state == SEQ_IDLE) && start_i && (total == '0));
  assign busy_o     = (state != SEQ_IDLE);
  assign shifting_o = (state == SEQ_SHIFT);
  assign sclk_o     = sclk_q;
  assign mosi_o     = busy_o & tx_sh[BYTE_W-1];

  for (genvar d = 0; d < NDEV; d++) begin : g_cs
    assign cs_n_o[d] = !(busy_o && (dev_q == DEV_W'(d)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state    <= SEQ_IDLE;
      kind_q   <= MSG_FULL_DUPLEX;
      rem      <= '0;
      pre_left <= '0;
      dev_q    <= '0;
      tx_sh    <= '0;
      rx_sh    <= '0;
      bit_q    <= '0;
      sclk_q   <= 1'b0;
      store_q  <= 1'b0;
    end else if (abort_i) begin
      state  <= SEQ_IDLE;
      sclk_q <= 1'b0;
    end else begin
      case (state)
        SEQ_IDLE: begin
          if (start_i && (total != '0)) begin
            kind_q   <= kind_i;
            dev_q    <= dev_i;
            rem      <= total;
            pre_left <= (kind_i == MSG_HALF_READ) ? pre_cnt_i : '0;
            state    <= SEQ_LOAD;
          end
        end
        SEQ_LOAD: begin
          tx_sh   <= (out_phase && !tx_empty_i) ? tx_byte_i : '0;
          store_q <= (kind_q == MSG_FULL_DUPLEX) ||
                     ((kind_q == MSG_HALF_READ) && (pre_left == '0));
          if ((kind_q == MSG_HALF_READ) && (pre_left != '0))
            pre_left <= pre_left - 1'b1;
          bit_q <= '0;
          state <= SEQ_SHIFT;
        end
        SEQ_SHIFT: begin
          if (strobe_i) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
              rx_sh  <= {rx_sh[BYTE_W-2:0], miso_i};
            end else begin
              sclk_q <= 1'b0;
              if (bit_q == 3'd7) begin
                state <= SEQ_END;
              end else begin
                bit_q <= bit_q + 1'b1;
                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
              end
            end
          end
        end
        SEQ_END: begin
          rem   <= rem - 1'b1;
          state <= (rem == TOT_W'(1)) ? SEQ_IDLE : SEQ_LOAD;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // R7
  cs_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~cs_n_o));
  // R7
  sclk_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&cs_n_o) |-> !sclk_o);
  // R7
  sclk_pace_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!strobe_i && !abort_i) |=> $stable(sclk_o));
endmodule

// File: rtl/spi_msg_master.sv
module spi_msg_master
  import spi_msg_pkg::*;
#(
  parameter int unsigned TX_DEPTH = 63,
  parameter int unsigned RX_DEPTH = 63,
  parameter int unsigned NDEV     = 4,
  localparam int unsigned DEV_W  = (NDEV > 1) ? $clog2(NDEV) : 1,
  localparam int unsigned TXC_W  = $clog2(TX_DEPTH + 1),
  localparam int unsigned RXC_W  = $clog2(RX_DEPTH + 1),
  localparam int unsigned MCNT_W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [3:0]      reg_addr_i,
  input  logic            reg_wr_i,
  input  logic            reg_rd_i,
  input  logic [7:0]      reg_wdata_i,
  output logic [7:0]      reg_rdata_o,
  output logic            irq_o,
  input  logic            shift_stb_i,
  output logic            sclk_o,
  output logic            mosi_o,
  input  logic            miso_i,
  output logic [NDEV-1:0] cs_n_o
);
  logic [MCNT_W-1:0] msg_cnt_q;
  msg_kind_e         msg_kind_q;
  logic [7:0]        cmd_hi_q;
  logic [DEV_W-1:0]  dev_q;
  logic [IRQ_W-1:0]  int_stat_q, int_mask_q, int_set, int_clr;

  logic              wr_cmd, cmd_hard, cmd_soft, cmd_start, flush;
  logic              tx_push, tx_pop, tx_full, tx_empty;
  logic              rx_push, rx_pop, rx_full, rx_empty;
  logic [7:0]        tx_head, rx_head, rx_in;
  logic [TXC_W-1:0]  tx_cnt;
  logic [RXC_W-1:0]  rx_cnt;
  logic              seq_unf, seq_done, seq_busy, seq_shift;

  assign wr_cmd    = reg_wr_i && (reg_addr_i == A_CMD_LO);
  assign cmd_hard  = wr_cmd && reg_wdata_i[2];
  assign cmd_soft  = wr_cmd && reg_wdata_i[1] && !reg_wdata_i[2];
  assign cmd_start = wr_cmd && reg_wdata_i[3] && !reg_wdata_i[2] && !reg_wdata_i[1];
  assign flush     = cmd_hard || cmd_soft;
  assign tx_push   = reg_wr_i && (reg_addr_i == A_TXD);
  assign rx_pop    = reg_rd_i && (reg_addr_i == A_RXD);

  spi_msg_fifo #(.DEPTH(TX_DEPTH), .DW(8)) u_tx_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(tx_push), .wdata_i(reg_wdata_i), .pop_i(tx_pop),
    .rdata_o(tx_head), .count_o(tx_cnt), .full_o(tx_full), .empty_o(tx_empty)
  );

  spi_msg_fifo #(.DEPTH(RX_DEPTH), .DW(8)) u_rx_fifo (
    .clk_i, .rst_ni, .flush_i(flush),
    .push_i(rx_push), .wdata_i(rx_in), .pop_i(rx_pop),
    .rdata_o(rx_head), .count_o(rx_cnt), .full_o(rx_full), .empty_o(rx_empty)
  );

  spi_msg_seq #(.CNT_W(MCNT_W), .NDEV(NDEV)) u_seq (
    .clk_i, .rst_ni, .abort_i(flush), .start_i(cmd_start),
    .kind_i(msg_kind_q), .byte_cnt_i(msg_cnt_q), .pre_cnt_i(cmd_hi_q[PRE_W-1:0]),
    .dev_i(reg_wdata_i[4 +: DEV_W]), .strobe_i(shift_stb_i), .miso_i,
    .tx_byte_i(tx_head), .tx_empty_i(tx_empty), .tx_pop_o(tx_pop),
    .tx_unf_o(seq_unf), .rx_push_o(rx_push), .rx_byte_o(rx_in),
    .done_o(seq_done), .busy_o(seq_busy), .shifting_o(seq_shift),
    .sclk_o, .mosi_o, .cs_n_o
  );

  always_comb begin
    int_set = '0;
    int_set[IRQ_DONE]   = seq_done;
    int_set[IRQ_RX_OVF] = rx_push && rx_full;
    int_set[IRQ_TX_UNF] = seq_unf;
    int_set[IRQ_TX_OVF] = tx_push && tx_full;
    int_set[IRQ_RX_UNF] = rx_pop && rx_empty;
    int_clr = (reg_wr_i && (reg_addr_i == A_INT_ST)) ? reg_wdata_i[IRQ_W-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      msg_cnt_q  <= '0;
      msg_kind_q <= MSG_FULL_DUPLEX;
      cmd_hi_q   <= '0;
      dev_q      <= '0;
      int_stat_q <= '0;
      int_mask_q <= '0;
    end else if (cmd_hard) begin
      msg_cnt_q  <= '0;
      msg_kind_q <= MSG_FULL_DUPLEX;
      cmd_hi_q   <= '0;
      dev_q      <= '0;
      int_stat_q <= '0;
      int_mask_q <= '0;
    end else begin
      int_stat_q <= (int_stat_q & ~int_clr) | int_set;
      if (reg_wr_i) begin
        case (reg_addr_i)
          A_CMD_LO:  dev_q      <= reg_wdata_i[4 +: DEV_W];
          A_CMD_HI:  cmd_hi_q   <= reg_wdata_i;
          A_MSG_LO:  msg_cnt_q  <= reg_wdata_i;
          A_MSG_HI:  msg_kind_q <= msg_kind_e'(reg_wdata_i[7:6]);
          A_INT_MSK: int_mask_q <= reg_wdata_i[IRQ_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (reg_addr_i)
      A_CMD_LO:  reg_rdata_o = 8'(dev_q) << 4;
      A_CMD_HI:  reg_rdata_o = cmd_hi_q;
      A_MSG_LO:  reg_rdata_o = msg_cnt_q;
      A_MSG_HI:  reg_rdata_o = {msg_kind_q, 6'b0};
      A_RXD:     reg_rdata_o = rx_empty ? 8'h00 : rx_head;
      A_STAT:    reg_rdata_o = {4'b0, seq_shift, seq_busy, rx_empty, 1'b0};
      A_INT_ST:  reg_rdata_o = 8'(int_stat_q);
      A_INT_MSK: reg_rdata_o = 8'(int_mask_q);
      A_TX_TAIL: reg_rdata_o = 8'(tx_cnt);
      A_RX_TAIL: reg_rdata_o = 8'(rx_cnt);
      default:   reg_rdata_o = 8'h00;
    endcase
  end

  assign irq_o = |(int_stat_q & int_mask_q);

  // R11
  w1c_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_wr_i && (reg_addr_i == A_INT_ST) && reg_wdata_i[IRQ_DONE] && !seq_done)
    |=> !int_stat_q[IRQ_DONE]);
  // R12
  soft_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_soft |=> (tx_empty && rx_empty && !seq_busy));
endmodule

// File: tb/sim_spi_msg_master.sv
module sim_spi_msg_master;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0, stb = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, sclk, mosi;
  logic [3:0] cs_n;
  logic [7:0] s_sh = 8'hFF, m_sh = '0;
  int         s_bit = 0, m_bit = 0;
  int         n_chk = 0, n_fail = 0;
  bit         finished = 0;
  byte unsigned sq[$];
  byte unsigned cap[$];
  wire        cs_idle = &cs_n;

  always #10 clk = ~clk;

  spi_msg_master u0 (
    .clk_i(clk), .rst_ni(rst_n), .reg_addr_i(addr), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq), .shift_stb_i(stb),
    .sclk_o(sclk), .mosi_o(mosi), .miso_i(s_sh[7]), .cs_n_o(cs_n)
  );

  function automatic logic [7:0] slave_next();
    if (sq.size() > 0) return sq.pop_front();
    return 8'hFF;
  endfunction

  always @(negedge cs_idle) begin
    s_sh  = slave_next();
    s_bit = 0;
    m_bit = 0;
  end
  always @(negedge sclk) if (!cs_idle) begin
    s_bit++;
    if (s_bit == 8) begin s_bit = 0; s_sh = slave_next(); end
    else s_sh = s_sh << 1;
  end
  always @(posedge sclk) begin
    m_sh = {m_sh[6:0], mosi};
    m_bit++;
    if (m_bit == 8) begin cap.push_back(m_sh); m_bit = 0; end
  end

  initial forever begin @(negedge clk); stb = ~stb; end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // per-clock model rules for the serial side
  always @(negedge clk) if (rst_n && !finished) begin
    chk("R7 one select", int'($countones(~cs_n) <= 1), 1);
    chk("R7 sclk idle", int'(cs_idle && sclk), 0);
  end

  task automatic wreg(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rreg(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1; #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic chk_reg(input string req, input logic [3:0] a, input logic [7:0] e);
    logic [7:0] d;
    rreg(a, d);
    chk(req, d, e);
  endtask

  task automatic wait_idle();
    logic [7:0] d;
    for (int i = 0; i < 20000; i++) begin
      rreg(4'h6, d);
      if (!d[2]) return;
    end
    chk("idle timeout", 1, 0);
  endtask

  task automatic chk_cap(input string req, input byte unsigned e[$]);
    chk({req, " count"}, cap.size(), e.size());
    foreach (e[i]) if (i < cap.size()) chk(req, cap[i], e[i]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 cs", cs_n, 4'hF); chk("R1 sclk", sclk, 0); chk("R1 irq", irq, 0);
    chk_reg("R1 status", 4'h6, 8'h02);
    chk_reg("R1 tx tail", 4'h9, 8'h00);
    chk_reg("R1 rx tail", 4'hA, 8'h00);

    // R2 R4 full duplex on device 2
    wreg(4'h2, 8'd3); wreg(4'h3, 8'h00); wreg(4'h8, 8'h01);
    wreg(4'h4, 8'hA5); wreg(4'h4, 8'h3C); wreg(4'h4, 8'hF0);
    chk_reg("R8 tail", 4'h9, 8'd3);
    sq = '{8'h5A, 8'hC3, 8'h0F}; cap.delete();
    wreg(4'h0, 8'h28);
    chk("R3 device 2 select", cs_n, 4'b1011);
    wait_idle();
    chk_cap("R4 mosi", '{8'hA5, 8'h3C, 8'hF0});
    chk("R11 irq", irq, 1);
    chk_reg("R4 rx0", 4'h5, 8'h5A);
    chk_reg("R4 rx1", 4'h5, 8'hC3);
    chk_reg("R4 rx2", 4'h5, 8'h0F);
    chk_reg("R11 status empty", 4'h6, 8'h02);
    chk_reg("R11 flags", 4'h7, 8'h01);
    wreg(4'h7, 8'h01);
    chk("R11 irq cleared", irq, 0);
    chk_reg("R11 w1c", 4'h7, 8'h00);

    // R5 half-duplex write
    wreg(4'h2, 8'd2); wreg(4'h3, 8'h40);
    wreg(4'h4, 8'h11); wreg(4'h4, 8'h22);
    sq = '{8'h77, 8'h88}; cap.delete();
    wreg(4'h0, 8'h08);
    wait_idle();
    chk_cap("R5 mosi", '{8'h11, 8'h22});
    chk_reg("R5 rx tail", 4'hA, 8'h00);
    chk_reg("R5 status", 4'h6, 8'h02);

    // R6 half-duplex read, prepend 1, device 1
    wreg(4'h1, 8'h01); wreg(4'h2, 8'd2); wreg(4'h3, 8'h80);
    wreg(4'h4, 8'h9F);
    sq = '{8'h01, 8'h02, 8'h03}; cap.delete();
    wreg(4'h0, 8'h18);
    chk("R6 device 1 select", cs_n, 4'b1101);
    wait_idle();
    chk_cap("R6 mosi", '{8'h9F, 8'h00, 8'h00});
    chk_reg("R6 rx tail", 4'hA, 8'd2);
    chk_reg("R6 rx0", 4'h5, 8'h02);
    chk_reg("R6 rx1", 4'h5, 8'h03);
    chk_reg("R6 flags", 4'h7, 8'h01);
    wreg(4'h7, 8'h1F); wreg(4'h1, 8'h00);

    // R9 transmit underflow
    wreg(4'h2, 8'd2); wreg(4'h3, 8'h00);
    wreg(4'h4, 8'h66);
    sq = '{8'hAA, 8'hBB}; cap.delete();
    wreg(4'h0, 8'h08);
    wait_idle();
    chk_cap("R9 mosi", '{8'h66, 8'h00});
    chk_reg("R9 flags", 4'h7, 8'h05);
    chk_reg("R9 rx0", 4'h5, 8'hAA);
    chk_reg("R9 rx1", 4'h5, 8'hBB);
    wreg(4'h7, 8'h1F);

    // R10 receive underflow
    chk_reg("R10 empty read", 4'h5, 8'h00);
    chk_reg("R10 rx unf flag", 4'h7, 8'h10);
    wreg(4'h7, 8'h1F);

    // R8 transmit overflow
    for (int i = 0; i < 64; i++) wreg(4'h4, 8'(i));
    chk_reg("R8 tail full", 4'h9, 8'd63);
    chk_reg("R8 ovf flag", 4'h7, 8'h08);
    wreg(4'h7, 8'h1F);

    // R3 priority: soft reset wins over start
    wreg(4'h0, 8'h0A);
    chk("R3 no select", cs_n, 4'hF);
    // R12 soft reset keeps configuration
    chk_reg("R12 tx flushed", 4'h9, 8'h00);
    chk_reg("R12 mask kept", 4'h8, 8'h01);
    chk_reg("R12 count kept", 4'h2, 8'd2);

    // R12 abort mid-message
    wreg(4'h2, 8'd4);
    wreg(4'h0, 8'h38);
    repeat (10) @(negedge clk);
    chk("R12 active", cs_n, 4'b0111);
    wreg(4'h0, 8'h02);
    chk("R12 abort cs", cs_n, 4'hF);
    chk("R12 abort sclk", sclk, 0);
    chk_reg("R12 abort status", 4'h6, 8'h02);
    wreg(4'h7, 8'h1F);

    // R10 receive overflow, 64 bytes read into a 63-byte FIFO
    wreg(4'h2, 8'd64); wreg(4'h3, 8'h80);
    sq.delete();
    for (int i = 0; i < 64; i++) sq.push_back(8'(i) ^ 8'h55);
    cap.delete();
    wreg(4'h0, 8'h08);
    wait_idle();
    chk_reg("R10 rx tail", 4'hA, 8'd63);
    chk_reg("R10 ovf flag", 4'h7, 8'h03);
    chk_reg("R10 first byte", 4'h5, 8'h55);
    wreg(4'h0, 8'h02);
    chk_reg("R12 rx flushed", 4'hA, 8'h00);
    wreg(4'h7, 8'h1F);

    // R13 zero-length start and no-op
    wreg(4'h2, 8'd0); wreg(4'h3, 8'h00);
    cap.delete();
    wreg(4'h0, 8'h08);
    chk("R13 zero len cs", cs_n, 4'hF);
    chk_reg("R13 zero len done", 4'h7, 8'h01);
    wreg(4'h7, 8'h1F);
    wreg(4'h2, 8'd2);
    wreg(4'h0, 8'h31);
    chk("R13 noop cs", cs_n, 4'hF);
    chk_reg("R13 noop status", 4'h6, 8'h02);
    chk_reg("R13 noop flags", 4'h7, 8'h00);
    chk("R13 no bytes", cap.size(), 0);

    // R12 hard reset clears configuration
    wreg(4'h8, 8'h1F); wreg(4'h1, 8'h05); wreg(4'h3, 8'h80);
    wreg(4'h0, 8'h04);
    chk_reg("R12 hard mask", 4'h8, 8'h00);
    chk_reg("R12 hard count", 4'h2, 8'h00);
    chk_reg("R12 hard kind", 4'h3, 8'h00);
    chk_reg("R12 hard cmd hi", 4'h1, 8'h00);
    chk("R12 hard irq", irq, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule